// File: doc/BRIEF.md
# Printer Port Output Register with Acknowledge Interrupt

This block is a write-only 16-bit output register that drives the lines of a parallel printer port and four status LEDs. It sits behind a peripheral chip select that covers a 2 KB window. Inside that window the register appears at every offset whose address bit 2 is zero, so it is aliased many times over. A CPU write to any alias loads the whole register at once. The low byte drives the printer data lines, the next four bits drive the printer control lines, and the top nibble drives the LEDs.

The block also holds a one-bit interrupt latch for the printer acknowledge line (`ack_n`). The printer signals that it is ready for more data with a falling edge on that line. The block synchronizes the line, detects the falling edge and raises `irq`. Software clears the latch as a side effect of touching the register. Any read or write to an alias whose address bit 1 is zero clears it. Aliases with address bit 1 set update the outputs but leave the interrupt pending, so the LEDs can be changed without losing an interrupt. Reads return zero; only their side effect matters.

Top module: `prn_port_ctl`

## Requirements
- R1: A write (`bus_cs`=1, `bus_wr`=1) to an offset with `bus_addr[2]`=0 loads the register, and the outputs show it from the next cycle. Data bit 15 drives `led[0]`, bit 14 drives `led[1]`, bit 13 drives `led[2]` and bit 12 drives `led[3]`.
- R2: Data bit 11 drives `prn_select_n`, bit 10 drives `prn_reset`, bit 9 drives `prn_linefeed_n` and bit 8 drives `prn_strobe_n`.
- R3: Data bits 7:0 drive `prn_data[7:0]` bit for bit.
- R4: A write with `bus_addr[2]`=1, or with `bus_cs`=0, leaves every output unchanged.
- R5: A read or a write with `bus_cs`=1, `bus_addr[2]`=0 and `bus_addr[1]`=0 clears `irq` at the next clock edge.
- R6: An access with `bus_addr[2]`=0 and `bus_addr[1]`=1 (for example offset 0x002) does not clear `irq`. An access with `bus_addr[2]`=1 does not clear it either.
- R7: `ack_n` passes through two synchronizer flops and then an edge detector. A falling edge sets `irq` at the third rising clock edge after the fall. A rising edge never sets it.
- R8: If a set and a clear fall in the same cycle, the set wins and `irq` stays 1.
- R9: While `rst` is high, every output is 0 and `irq` is 0. A high `ack_n` held through reset does not set `irq` afterwards.
- R10: `bus_rdata` is always zero, and a read never changes the port or LED outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Select of the 2 KB peripheral window |
| bus_addr | input | 11 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one access per asserted cycle |
| bus_wr | input | 1 | Write strobe, one access per asserted cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, always zero |
| prn_data | output | 8 | Printer data lines |
| prn_strobe_n | output | 1 | Printer strobe line (register bit 8) |
| prn_linefeed_n | output | 1 | Printer auto line feed line (register bit 9) |
| prn_reset | output | 1 | Printer reset line (register bit 10) |
| prn_select_n | output | 1 | Printer select line (register bit 11) |
| led | output | 4 | Status LEDs |
| ack_n | input | 1 | Asynchronous printer acknowledge, falling edge is the event |
| irq | output | 1 | Pending acknowledge interrupt, active high |

## Verification
The bench writes a distinct value to every one of the 2048 offsets. After each write it checks that only the offsets with bit 2 clear load the register. A decoder that looked at the wrong bit, or at more bits, would miss aliases or load on forbidden offsets. It then sets the interrupt and sweeps reads and writes across the low offsets. This catches a design that clears on address bit 1 set, clears only on writes, or also clears from the forbidden aliases. It also times the acknowledge path to the exact edge and lands a clearing access on the cycle of the set. A design with the wrong synchronizer depth, with rising-edge detection or with clear priority fails there.

// File: rtl/prn_pkg.sv
package prn_pkg;

    localparam int WORD_W = 16;
    localparam int LED_N  = 4;
    localparam int PDAT_W = 8;

    // Register image, most significant field first.
    typedef struct packed {
        logic [LED_N-1:0]  led_hi;   // bit 15 -> led[0] ... bit 12 -> led[3]
        logic              sel_n;    // bit 11
        logic              prst;     // bit 10
        logic              lf_n;     // bit 9
        logic              stb_n;    // bit 8
        logic [PDAT_W-1:0] pdat;     // bits 7:0
    } port_word_t;

    // Decoded effect of one bus cycle.
    typedef struct packed {
        logic load;
        logic clear;
    } bus_act_t;

    function automatic logic [LED_N-1:0] led_order(input logic [LED_N-1:0] f);
        logic [LED_N-1:0] r;
        for (int i = 0; i < LED_N; i++) begin
            r[i] = f[LED_N-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/prn_bus_decode.sv
module prn_bus_decode
    import prn_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int ALIAS_BIT = 2,
    parameter int CLR_BIT   = 1
) (
    input  logic              cs,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output bus_act_t          act
);
    logic in_win;

    always_comb begin
        in_win    = cs && !addr[ALIAS_BIT];
        act.load  = in_win && wr;
        act.clear = in_win && (rd || wr) && !addr[CLR_BIT];
    end

endmodule

// File: rtl/prn_ack_edge.sv
module prn_ack_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_n,
    output logic fall
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[CHAIN-2:0], ack_n};
        end
    end

    // Last stage still high, previous stage already low.
    always_comb fall = chain[CHAIN-1] && !chain[CHAIN-2];

endmodule

// File: rtl/prn_irq_latch.sv
module prn_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clear,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (set) begin
            pending <= 1'b1;
        end else if (clear) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/prn_out_reg.sv
module prn_out_reg
    import prn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] wdata,
    output port_word_t        word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (load) begin
            word <= port_word_t'(wdata);
        end
    end

endmodule

// File: rtl/prn_port_ctl.sv
module prn_port_ctl
    import prn_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int ALIAS_BIT   = 2,
    parameter int CLR_BIT     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_cs,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [7:0]        prn_data,
    output logic              prn_strobe_n,
    output logic              prn_linefeed_n,
    output logic              prn_reset,
    output logic              prn_select_n,
    output logic [3:0]        led,
    input  logic              ack_n,
    output logic              irq
);
    bus_act_t   act;
    port_word_t word;
    logic       ack_fall;

    prn_bus_decode #(
        .ADDR_W   (ADDR_W),
        .ALIAS_BIT(ALIAS_BIT),
        .CLR_BIT  (CLR_BIT)
    ) i_decode (
        .cs  (bus_cs),
        .addr(bus_addr),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .act (act)
    );

    prn_out_reg i_reg (
        .clk  (clk),
        .rst  (rst),
        .load (act.load),
        .wdata(bus_wdata),
        .word (word)
    );

    prn_ack_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_edge (
        .clk  (clk),
        .rst  (rst),
        .ack_n(ack_n),
        .fall (ack_fall)
    );

    prn_irq_latch i_irq (
        .clk    (clk),
        .rst    (rst),
        .set    (ack_fall),
        .clear  (act.clear),
        .pending(irq)
    );

    always_comb begin
        bus_rdata      = '0;
        prn_data       = word.pdat;
        prn_strobe_n   = word.stb_n;
        prn_linefeed_n = word.lf_n;
        prn_reset      = word.prst;
        prn_select_n   = word.sel_n;
        led            = led_order(word.led_hi);
    end

endmodule

// File: rtl/prn_port_ctl_chk.sv
module prn_port_ctl_chk #(
    parameter int ADDR_W    = 11,
    parameter int ALIAS_BIT = 2,
    parameter int CLR_BIT   = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_cs,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic [7:0]        prn_data,
    input logic              prn_strobe_n,
    input logic              prn_linefeed_n,
    input logic              prn_reset,
    input logic              prn_select_n,
    input logic [3:0]        led,
    input logic              ack_fall,
    input logic              irq
);
    logic [15:0] outs;
    logic        hit_wr;
    logic        hit_clr;
    logic        hit_keep;

    assign outs = {led[0], led[1], led[2], led[3], prn_select_n, prn_reset,
                   prn_linefeed_n, prn_strobe_n, prn_data};
    assign hit_wr   = bus_cs && bus_wr && !bus_addr[ALIAS_BIT];
    assign hit_clr  = bus_cs && (bus_rd || bus_wr) && !bus_addr[ALIAS_BIT] && !bus_addr[CLR_BIT];
    assign hit_keep = !(bus_cs && (bus_rd || bus_wr) && !bus_addr[ALIAS_BIT] && !bus_addr[CLR_BIT]);

    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        hit_wr |=> outs == $past(bus_wdata));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !hit_wr |=> $stable(outs));

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (hit_clr && !ack_fall) |=> !irq);

    a_r6_keep: assert property (@(posedge clk) disable iff (rst)
        (hit_keep && irq) |=> irq);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        ack_fall |=> irq);

    a_r9_reset: assert property (@(posedge clk)
        rst |=> (outs == 16'h0 && !irq));

    always_comb begin
        a_r10_rdata_zero: assert (bus_rdata == 16'h0);
    end

endmodule

bind prn_port_ctl prn_port_ctl_chk #(
    .ADDR_W   (ADDR_W),
    .ALIAS_BIT(ALIAS_BIT),
    .CLR_BIT  (CLR_BIT)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_cs        (bus_cs),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .prn_data      (prn_data),
    .prn_strobe_n  (prn_strobe_n),
    .prn_linefeed_n(prn_linefeed_n),
    .prn_reset     (prn_reset),
    .prn_select_n  (prn_select_n),
    .led           (led),
    .ack_fall      (ack_fall),
    .irq           (irq)
);

// File: tb/test_prn_port_ctl.sv
module test_prn_port_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cs = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  prn_data;
    logic        prn_strobe_n, prn_linefeed_n, prn_reset, prn_select_n;
    logic [3:0]  led;
    logic        ack_n = 1'b1;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_word = '0;

    always #4 clk = ~clk;

    prn_port_ctl i_prn_port_ctl (
        .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .prn_data(prn_data), .prn_strobe_n(prn_strobe_n),
        .prn_linefeed_n(prn_linefeed_n), .prn_reset(prn_reset),
        .prn_select_n(prn_select_n), .led(led), .ack_n(ack_n), .irq(irq)
    );

    // Register image rebuilt from pins using the bit map of R1, R2 and R3.
    function automatic logic [15:0] pins_word();
        return {led[0], led[1], led[2], led[3], prn_select_n, prn_reset,
                prn_linefeed_n, prn_strobe_n, prn_data};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic cs, input logic [10:0] a, input logic rd,
                          input logic wr, input logic [15:0] d);
        @(negedge clk);
        bus_cs = cs; bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    // Falling edge on ack_n, then wait until irq must be set (third edge).
    task automatic raise_irq();
        @(negedge clk);
        ack_n = 1'b0;
        repeat (3) @(negedge clk);
        ack_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 outputs in reset", {16'h0, pins_word()}, 32'h0);
        chk("R9 irq in reset", {31'h0, irq}, 32'h0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R9 no irq after reset with ack_n high", {31'h0, irq}, 32'h0);

        // R1, R2, R3: walking one across each data bit
        for (int b = 0; b < 16; b++) begin
            access(1'b1, 11'h000, 1'b0, 1'b1, 16'h1 << b);
            chk("R1 R2 R3 walking bit", {16'h0, pins_word()}, 32'h1 << b);
        end
        access(1'b1, 11'h000, 1'b0, 1'b1, 16'h8000);
        chk("R1 bit15 drives led0", {28'h0, led}, 32'h1);
        access(1'b1, 11'h000, 1'b0, 1'b1, 16'h0800);
        chk("R2 bit11 drives select", {31'h0, prn_select_n}, 32'h1);
        access(1'b1, 11'h000, 1'b0, 1'b1, 16'h0100);
        chk("R2 bit8 drives strobe", {31'h0, prn_strobe_n}, 32'h1);
        access(1'b1, 11'h000, 1'b0, 1'b1, 16'h00A5);
        chk("R3 data byte", {24'h0, prn_data}, 32'hA5);
        exp_word = 16'h00A5;

        // R1, R4: sweep every offset, alias decode on bit 2
        for (int a = 0; a < 2048; a++) begin
            logic [15:0] d;
            d = 16'(a * 16'h9E37 + 16'h1234);
            access(1'b1, 11'(a), 1'b0, 1'b1, d);
            if (((a >> 2) & 1) == 0) exp_word = d;
            chk(((a >> 2) & 1) == 0 ? "R1 alias write loads" : "R4 bit2 write ignored",
                {16'h0, pins_word()}, {16'h0, exp_word});
        end

        // R4: chip select low
        for (int a = 0; a < 64; a++) begin
            access(1'b0, 11'(a * 32), 1'b0, 1'b1, ~exp_word);
            chk("R4 cs low write ignored", {16'h0, pins_word()}, {16'h0, exp_word});
        end

        // R10: reads return zero and leave outputs
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            bus_cs = 1'b1; bus_addr = 11'(a); bus_rd = 1'b1; bus_wdata = ~exp_word;
            #1;
            chk("R10 rdata zero", {16'h0, bus_rdata}, 32'h0);
            @(negedge clk);
            bus_cs = 1'b0; bus_rd = 1'b0;
            chk("R10 read keeps outputs", {16'h0, pins_word()}, {16'h0, exp_word});
        end

        // R7: latency of the acknowledge path, falling edge only
        @(negedge clk);
        ack_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 irq not yet after two edges", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq set at third edge", {31'h0, irq}, 32'h1);
        access(1'b1, 11'h000, 1'b1, 1'b0, 16'h0);
        chk("R5 read at offset 0 clears", {31'h0, irq}, 32'h0);
        ack_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 rising edge does not set", {31'h0, irq}, 32'h0);

        // R5, R6: clear decode over low offsets, reads and writes
        for (int a = 0; a < 32; a++) begin
            for (int k = 0; k < 2; k++) begin
                logic clr;
                raise_irq();
                chk("R7 irq set before access", {31'h0, irq}, 32'h1);
                clr = (((a >> 2) & 1) == 0) && (((a >> 1) & 1) == 0);
                access(1'b1, 11'(a), k == 0, k == 1, exp_word);
                chk(clr ? "R5 access clears irq" : "R6 access keeps irq",
                    {31'h0, irq}, {31'h0, !clr});
                if (!clr) access(1'b1, 11'h000, 1'b1, 1'b0, 16'h0);
            end
        end
        access(1'b0, 11'h000, 1'b1, 1'b1, 16'h0);
        raise_irq();
        access(1'b0, 11'h000, 1'b1, 1'b1, exp_word);
        chk("R6 cs low access keeps irq", {31'h0, irq}, 32'h1);
        access(1'b1, 11'h000, 1'b1, 1'b0, 16'h0);

        // R8: clear lands in the cycle of the set
        @(negedge clk);
        ack_n = 1'b0;
        @(negedge clk);
        bus_cs = 1'b1; bus_addr = 11'h000; bus_rd = 1'b1;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0;
        chk("R8 before set cycle cleared nothing", {31'h0, irq}, 32'h0);
        bus_cs = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_cs = 1'b0; bus_rd = 1'b0;
        chk("R8 set wins over clear", {31'h0, irq}, 32'h1);
        ack_n = 1'b1;

        // R9: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset clears outputs", {16'h0, pins_word()}, 32'h0);
        chk("R9 reset clears irq", {31'h0, irq}, 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule